// File: doc/BRIEF.md
# FIFO Level Interrupt and DMA Request Unit

This block sits beside the transmit and receive sample FIFOs of a serial audio/SPI controller. It compares each FIFO's fill level, counted in samples, against a programmed threshold. The comparison runs in opposite directions for the two FIFOs: the transmit side flags when the level has drained down to its mark, and the receive side flags when the level has climbed up to its mark. It also keeps sticky flags for transmit underrun and receive overrun events. Software enables any of these four flags onto a single level interrupt line.

For each direction a request/acknowledge pair towards a DMA engine is also driven. A request rises when that direction's DMA enable is set and its level condition holds. It stays up until the engine acknowledges. On the acknowledge it takes the current condition, so a still-hungry channel asks again at once.

Software writes one control word and reads one status word. Reading the status word clears the two event flags. The two level flags keep tracking the FIFOs. While the controller enable input is low, the status flags and the interrupt line are frozen. The register port is a plain strobe interface with no back-pressure: a write or read strobe is accepted in the cycle it is high.

Top module: `fifo_thr_irq_dma`

## Requirements
- R1: In reset, and until the first write, the control readback is 0x02200 and the status word is 0x8. The internal thresholds are both 0, the interrupt is low and both DMA requests are low.
- R2: At every clock edge with `ctl_en` high, status bit 3 becomes 1 if `tx_level` is less than or equal to the TX threshold, and 0 otherwise.
- R3: At every clock edge with `ctl_en` high, status bit 2 becomes 1 if `rx_level` is greater than or equal to the RX threshold, and 0 otherwise. When `frame_fmt` equals 3'd1 (SPI format), status bit 2 becomes 1 regardless of level.
- R4: A control write loads the TX threshold from write data bits [16:12] and the RX threshold from bits [11:7]. Thresholds change only on a write, so the 0x02200 reset readback does not act as a threshold.
- R5: Status bit 1 (underrun) is set by a `tx_urun_evt` pulse, and status bit 0 (overrun) by a `rx_orun_evt` pulse, at an edge with `ctl_en` high. Both stay set until a status read. A pulse arriving with the read wins, and the bit stays set.
- R6: `stat_rdata` always shows the current status. An edge with `stat_rd` high clears bits 1 and 0, whether or not `ctl_en` is high. Bits 3 and 2 are not cleared by a read.
- R7: After each edge with `ctl_en` high, `irq` equals the OR of control bits [3:0] ANDed with status bits [3:0], both as seen after that edge.
- R8: At an edge with `ctl_en` low, status bits 3 and 2 hold, event pulses are ignored and `irq` holds.
- R9: `dma_req[0]` (TX) and `dma_req[1]` (RX) go high at an edge where `ctl_en` is high, the direction's DMA enable is set (control bit 5 for TX, bit 4 for RX) and its R2/R3 condition holds. A request is not lowered when the condition goes away; only an acknowledge lowers it.
- R10: An edge with `dma_ack[c]` high and that direction's DMA enable set loads `dma_req[c]` with the current condition, regardless of `ctl_en`. An acknowledge with the DMA enable clear has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_en | input | 1 | Controller enable; gates status and interrupt updates |
| frame_fmt | input | 3 | Frame format code; 3'd1 is SPI |
| tx_level | input | LVL_W (5) | TX FIFO fill in samples |
| rx_level | input | LVL_W (5) | RX FIFO fill in samples |
| tx_urun_evt | input | 1 | One-cycle TX underrun event |
| rx_orun_evt | input | 1 | One-cycle RX overrun event |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 17 | Control word write data |
| ctrl_word | output | 17 | Control word readback |
| stat_rd | input | 1 | Status read strobe (clears event flags) |
| stat_rdata | output | 4 | Status word |
| irq | output | 1 | Level interrupt |
| dma_req | output | 2 | DMA requests, [0] TX, [1] RX |
| dma_ack | input | 2 | DMA acknowledges, [0] TX, [1] RX |

## Verification
The level comparators are swept level by level across each threshold, including zero and the full value of 16. This separates a strict comparison from an inclusive one, and catches a comparison made in the wrong direction. Reads and event pulses are placed in the same cycle and in adjacent cycles, which shows whether an event is lost to a read. Acknowledges are given with the condition still true, with it false, and with DMA disabled. These show re-arm, drop and ignore apart. A long stretch of random levels, formats, strobes and enable toggles is compared against a cycle-level reference model on every clock.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;
  localparam int CTRL_W    = 17;
  localparam int THR_W     = 5;
  localparam int STAT_W    = 4;
  localparam int FMT_W     = 3;
  localparam int NCH       = 2;
  localparam int CH_TX     = 0;
  localparam int CH_RX     = 1;

  // field positions inside the control word
  localparam int TXTHR_LSB = 12;
  localparam int RXTHR_LSB = 7;
  localparam int TXDMA_BIT = 5;
  localparam int RXDMA_BIT = 4;

  // status bit positions (same positions act as interrupt enables)
  localparam int ST_TXTHR  = 3;
  localparam int ST_RXTHR  = 2;
  localparam int ST_URUN   = 1;
  localparam int ST_ORUN   = 0;

  localparam logic [CTRL_W-1:0] CTRL_RST = 17'h02200;
  localparam logic [STAT_W-1:0] STAT_RST = 4'h8;
  localparam logic [FMT_W-1:0]  FMT_SPI  = 3'd1;
endpackage

// File: rtl/thr_ctrl_regs.sv
module thr_ctrl_regs
  import fifo_thr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [STAT_W-1:0] int_en_nxt,
  output logic [THR_W-1:0]  tx_thr,
  output logic [THR_W-1:0]  rx_thr
);
  logic [CTRL_W-1:0] ctrl_nxt;

  assign ctrl_nxt   = wr ? wdata : ctrl_q;
  assign int_en_nxt = ctrl_nxt[STAT_W-1:0];

  // thresholds are separate registers: they load only from a write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      tx_thr <= '0;
      rx_thr <= '0;
    end else if (wr) begin
      ctrl_q <= wdata;
      tx_thr <= wdata[TXTHR_LSB +: THR_W];
      rx_thr <= wdata[RXTHR_LSB +: THR_W];
    end
  end
endmodule

// File: rtl/thr_status.sv
module thr_status
  import fifo_thr_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              spi_fmt,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [THR_W-1:0]  tx_thr,
  input  logic [THR_W-1:0]  rx_thr,
  input  logic              urun,
  input  logic              orun,
  input  logic              rd,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] status_nxt,
  output logic              tx_cond,
  output logic              rx_cond
);
  localparam int CW = (LVL_W > THR_W) ? LVL_W : THR_W;

  logic [CW-1:0] tx_lvl_x, rx_lvl_x, tx_thr_x, rx_thr_x;

  assign tx_lvl_x = CW'(tx_level);
  assign rx_lvl_x = CW'(rx_level);
  assign tx_thr_x = CW'(tx_thr);
  assign rx_thr_x = CW'(rx_thr);

  // transmit drains toward its mark, receive fills toward its mark
  assign tx_cond = (tx_lvl_x <= tx_thr_x);
  assign rx_cond = spi_fmt || (rx_lvl_x >= rx_thr_x);

  always_comb begin
    status_nxt = status_q;
    if (rd) begin
      status_nxt[ST_URUN] = 1'b0;
      status_nxt[ST_ORUN] = 1'b0;
    end
    if (en) begin
      status_nxt[ST_TXTHR] = tx_cond;
      status_nxt[ST_RXTHR] = rx_cond;
      if (urun) status_nxt[ST_URUN] = 1'b1;
      if (orun) status_nxt[ST_ORUN] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= STAT_RST;
    else        status_q <= status_nxt;
  end
endmodule

// File: rtl/thr_dma_chan.sv
module thr_dma_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dma_en,
  input  logic cond,
  input  logic ack,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               req <= 1'b0;
    else if (ack && dma_en)   req <= cond;
    else if (en && dma_en && cond) req <= 1'b1;
  end
endmodule

// File: rtl/fifo_thr_irq_dma.sv
module fifo_thr_irq_dma
  import fifo_thr_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_en,
  input  logic [FMT_W-1:0]  frame_fmt,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              tx_urun_evt,
  input  logic              rx_orun_evt,
  input  logic              cfg_wr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] ctrl_word,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_rdata,
  output logic              irq,
  output logic [NCH-1:0]    dma_req,
  input  logic [NCH-1:0]    dma_ack
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [STAT_W-1:0] int_en_nxt;
  logic [THR_W-1:0]  tx_thr, rx_thr;
  logic [STAT_W-1:0] status_q, status_nxt;
  logic              tx_cond, rx_cond;
  logic [NCH-1:0]    cond_v, dma_en_v;
  logic              irq_q;

  thr_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .ctrl_q(ctrl_q), .int_en_nxt(int_en_nxt),
    .tx_thr(tx_thr), .rx_thr(rx_thr)
  );

  thr_status #(.LVL_W(LVL_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .en(ctl_en),
    .spi_fmt(frame_fmt == FMT_SPI),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr), .rx_thr(rx_thr),
    .urun(tx_urun_evt), .orun(rx_orun_evt), .rd(stat_rd),
    .status_q(status_q), .status_nxt(status_nxt),
    .tx_cond(tx_cond), .rx_cond(rx_cond)
  );

  assign cond_v[CH_TX]   = tx_cond;
  assign cond_v[CH_RX]   = rx_cond;
  assign dma_en_v[CH_TX] = ctrl_q[TXDMA_BIT];
  assign dma_en_v[CH_RX] = ctrl_q[RXDMA_BIT];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    thr_dma_chan u_chan (
      .clk(clk), .rst_n(rst_n), .en(ctl_en),
      .dma_en(dma_en_v[c]), .cond(cond_v[c]),
      .ack(dma_ack[c]), .req(dma_req[c])
    );
  end

  // interrupt frozen while the controller is disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (ctl_en) irq_q <= |(int_en_nxt & status_nxt);
  end

  assign irq        = irq_q;
  assign stat_rdata = status_q;
  assign ctrl_word  = ctrl_q;
endmodule

// File: rtl/thr_irq_dma_chk.sv
module thr_irq_dma_chk
  import fifo_thr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_en,
  input logic [FMT_W-1:0]  frame_fmt,
  input logic              rx_orun_evt,
  input logic              stat_rd,
  input logic [STAT_W-1:0] stat_rdata,
  input logic              irq,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic [NCH-1:0]    dma_req,
  input logic [NCH-1:0]    dma_ack
);
  p_spi_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && frame_fmt == FMT_SPI) |=> stat_rdata[ST_RXTHR]);

  p_orun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && rx_orun_evt) |=> stat_rdata[ST_ORUN]);

  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(ctl_en && rx_orun_evt)) |=> !stat_rdata[ST_ORUN]);

  p_irq_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en |=> (irq == |(ctrl_word[STAT_W-1:0] & stat_rdata)));

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> $stable(irq));

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> $stable(stat_rdata[ST_TXTHR:ST_RXTHR]));

  p_tx_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req[CH_TX] && !dma_ack[CH_TX]) |=> dma_req[CH_TX]);

  p_rx_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req[CH_RX] && !dma_ack[CH_RX]) |=> dma_req[CH_RX]);

  p_spi_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack[CH_RX] && ctrl_word[RXDMA_BIT] && frame_fmt == FMT_SPI) |=> dma_req[CH_RX]);
endmodule

bind fifo_thr_irq_dma thr_irq_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .frame_fmt(frame_fmt),
  .rx_orun_evt(rx_orun_evt), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
  .irq(irq), .ctrl_word(ctrl_word), .dma_req(dma_req), .dma_ack(dma_ack)
);

// File: tb/fifo_thr_irq_dma_tb.sv
`timescale 1ns/1ps
module fifo_thr_irq_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_en = 1'b0;
  logic [2:0]  frame_fmt = 3'd0;
  logic [4:0]  tx_level = '0, rx_level = '0;
  logic        tx_urun_evt = 1'b0, rx_orun_evt = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [16:0] cfg_wdata = '0;
  logic [16:0] ctrl_word;
  logic        stat_rd = 1'b0;
  logic [3:0]  stat_rdata;
  logic        irq;
  logic [1:0]  dma_req;
  logic [1:0]  dma_ack = '0;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  fifo_thr_irq_dma dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .frame_fmt(frame_fmt),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_urun_evt(tx_urun_evt), .rx_orun_evt(rx_orun_evt),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .ctrl_word(ctrl_word),
    .stat_rd(stat_rd), .stat_rdata(stat_rdata), .irq(irq),
    .dma_req(dma_req), .dma_ack(dma_ack)
  );

  // behavioural reference
  int m_ctrl = 'h2200, m_stat = 8, m_txthr = 0, m_rxthr = 0;
  bit m_irq = 0;
  bit m_req [2] = '{0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 'h2200; m_stat = 8; m_txthr = 0; m_rxthr = 0;
      m_irq = 0; m_req[0] = 0; m_req[1] = 0;
    end else begin
      int nctrl, st;
      bit cnd [2];
      nctrl = cfg_wr ? int'(cfg_wdata) : m_ctrl;
      cnd[0] = int'(tx_level) <= m_txthr;
      cnd[1] = (frame_fmt == 3'd1) || (int'(rx_level) >= m_rxthr);
      st = m_stat;
      if (stat_rd) st = st & 'hC;
      if (ctl_en) begin
        st = (st & 3) | (cnd[0] ? 8 : 0) | (cnd[1] ? 4 : 0);
        if (tx_urun_evt) st = st | 2;
        if (rx_orun_evt) st = st | 1;
      end
      for (int c = 0; c < 2; c++) begin
        bit den;
        den = ((m_ctrl >> (5 - c)) & 1) != 0;
        if (dma_ack[c] && den) m_req[c] = cnd[c];
        else if (ctl_en && den && cnd[c]) m_req[c] = 1;
      end
      if (ctl_en) m_irq = ((nctrl & st & 'hF) != 0);
      if (cfg_wr) begin
        m_txthr = (int'(cfg_wdata) >> 12) & 'h1F;
        m_rxthr = (int'(cfg_wdata) >> 7) & 'h1F;
      end
      m_ctrl = nctrl; m_stat = st;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R4 ctrl", int'(ctrl_word), m_ctrl);
    check("R2 txflag", int'(stat_rdata[3]), (m_stat >> 3) & 1);
    check("R3 rxflag", int'(stat_rdata[2]), (m_stat >> 2) & 1);
    check("R5 events", int'(stat_rdata[1:0]), m_stat & 3);
    check("R7 irq", int'(irq), int'(m_irq));
    check("R9 txreq", int'(dma_req[0]), int'(m_req[0]));
    check("R10 rxreq", int'(dma_req[1]), int'(m_req[1]));
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    cfg_wr = 0; stat_rd = 0; tx_urun_evt = 0; rx_orun_evt = 0; dma_ack = '0;
  endtask

  task automatic wr_ctrl(input int txt, input int rxt, input int dmaen, input int ien);
    cfg_wdata = 17'((txt << 12) | (rxt << 7) | (dmaen << 4) | ien);
    cfg_wr = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values, explicit
    check("R1 ctrl_rst", int'(ctrl_word), 'h2200);
    check("R1 stat_rst", int'(stat_rdata), 8);
    check("R1 irq_rst", int'(irq), 0);
    check("R1 req_rst", int'(dma_req), 0);
    rst_n = 1;

    // R8: disabled, events and level changes ignored
    phase = "R8";
    tx_level = 9; tx_urun_evt = 1; rx_orun_evt = 1; step();
    step();
    check("R8 frozen", int'(stat_rdata), 8);

    // R4: reset readback is not a threshold (thr 0, level 1 -> flag clear)
    phase = "R4";
    ctl_en = 1; tx_level = 1; rx_level = 0; step();
    check("R4 no_rst_thr", int'(stat_rdata[3]), 0);
    wr_ctrl(4, 6, 3, 'hF); step();
    step();

    // R2 / R3 sweeps across thresholds
    phase = "R2";
    for (int l = 0; l <= 16; l++) begin tx_level = 5'(l); step(); end
    phase = "R3";
    for (int l = 16; l >= 0; l--) begin rx_level = 5'(l); step(); end
    frame_fmt = 3'd1; rx_level = 0; step();
    check("R3 spi_forced", int'(stat_rdata[2]), 1);
    frame_fmt = 3'd3; step();

    // R5 / R6: events, reads, collisions
    phase = "R5";
    tx_urun_evt = 1; step();
    step();
    rx_orun_evt = 1; stat_rd = 1; step();
    check("R5 evt_wins", int'(stat_rdata[0]), 1);
    phase = "R6";
    stat_rd = 1; step();
    check("R6 rd_clears", int'(stat_rdata[1:0]), 0);
    tx_level = 2; stat_rd = 1; step();
    check("R6 thr_kept", int'(stat_rdata[3]), 1);

    // R9 / R10: request hold, ack drop and re-arm, ack ignored
    phase = "R9";
    tx_level = 2; step();
    tx_level = 10; step();
    check("R9 req_held", int'(dma_req[0]), 1);
    phase = "R10";
    dma_ack[0] = 1; step();
    check("R10 ack_drop", int'(dma_req[0]), 0);
    tx_level = 0; step();
    dma_ack[0] = 1; step();
    check("R10 ack_rearm", int'(dma_req[0]), 1);
    wr_ctrl(4, 6, 0, 'hF); step();
    dma_ack = 2'b11; tx_level = 12; step();
    check("R10 ack_ignored", int'(dma_req), 3);
    wr_ctrl(4, 6, 3, 'hF); step();

    // R8 while enabled state exists, then read while disabled
    phase = "R8";
    rx_orun_evt = 1; step();
    ctl_en = 0; tx_level = 0; rx_level = 16; stat_rd = 1; step();
    check("R8 rd_when_off", int'(stat_rdata[0]), 0);
    ctl_en = 1; step();

    // random mixed traffic
    phase = "R7";
    for (int i = 0; i < 3000; i++) begin
      tx_level    = 5'($urandom_range(0, 16));
      rx_level    = 5'($urandom_range(0, 16));
      frame_fmt   = 3'($urandom_range(0, 4));
      ctl_en      = ($urandom_range(0, 7) != 0);
      tx_urun_evt = ($urandom_range(0, 9) == 0);
      rx_orun_evt = ($urandom_range(0, 9) == 0);
      stat_rd     = ($urandom_range(0, 5) == 0);
      dma_ack     = 2'($urandom_range(0, 3) & {2{$urandom_range(0, 2) == 0}});
      if ($urandom_range(0, 40) == 0)
        wr_ctrl($urandom_range(0, 20), $urandom_range(0, 20),
                $urandom_range(0, 3), $urandom_range(0, 15));
      step();
    end

    finish_run();
  end
endmodule